// File: doc/BRIEF.md
# Second-Operand Shifter with Carry Generation

This block builds the second operand of a 32-bit data-processing datapath together with the carry value that a flag-setting operation would commit. It is purely combinational. It has two forms. In immediate form, an 8-bit constant is rotated right by an even amount taken from a 4-bit field. In register form, a register value goes through one of four shift kinds. The amount comes either from a 5-bit field or from the low byte of a second register.

The shift kinds use the encoding 0 = logical left, 1 = logical right, 2 = arithmetic right and 3 = rotate right. Amounts of zero, exactly 32 and more than 32 each have their own result and carry rule. A zero amount in the 5-bit field is read differently for each shift kind. When the set-flags input is low, the carry output simply repeats the incoming carry.

Top module: `sop_shifter_unit`

## Requirements
- R1: With `use_imm`=1, `operand_out` equals `{24'b0, imm_val}` rotated right by `2*imm_rot`. When that amount is nonzero, `carry_out` is `operand_out[31]`. When it is zero, `carry_out` is `carry_in`. This assumes `set_flags`=1.
- R2: With `use_imm`=0 and `amt_from_reg`=1, the shift amount is `cnt_reg[7:0]`. Bits `cnt_reg[31:8]` have no effect on either output.
- R3: A register-sourced amount of 0 leaves `operand_out` equal to `src_val` and `carry_out` equal to `carry_in`, for every shift kind.
- R4: Logical left (`sh_type`=0) by n in 1..31 shifts in zeros, and carry is `src_val[32-n]`. At n=32 the result is 0 and carry is `src_val[0]`. For n>32 the result is 0 and carry is 0.
- R5: Logical right (`sh_type`=1) by n in 1..31 shifts in zeros, and carry is `src_val[n-1]`. At n=32 the result is 0 and carry is `src_val[31]`. For n>32 the result is 0 and carry is 0.
- R6: Arithmetic right (`sh_type`=2) by n in 1..31 fills with `src_val[31]`, and carry is `src_val[n-1]`. For n>=32 every result bit equals `src_val[31]`, and so does carry.
- R7: Rotate right (`sh_type`=3) by a nonzero n rotates by n mod 32. Carry is bit 31 of the rotated result.
- R8: With `amt_from_reg`=0 and `amt_imm`=0, logical left performs no shift and keeps `carry_in`. Logical right and arithmetic right behave as shifts by 32.
- R9: With `amt_from_reg`=0, `amt_imm`=0 and `sh_type`=3, the result is `{carry_in, src_val[31:1]}` and carry is `src_val[0]`.
- R10: With `set_flags`=0, `carry_out` equals `carry_in` in every form and for every amount.
- R11: With `use_imm`=1, the outputs do not depend on `src_val`, `sh_type`, `amt_from_reg`, `amt_imm` or `cnt_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects immediate form, 0 selects register form |
| imm_val | input | 8 | Constant for immediate form |
| imm_rot | input | 4 | Half of the right-rotate amount for immediate form |
| src_val | input | 32 | Register value to shift |
| sh_type | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| amt_from_reg | input | 1 | 1 takes the amount from `cnt_reg`, 0 from `amt_imm` |
| amt_imm | input | 5 | Encoded shift amount field |
| cnt_reg | input | 32 | Register holding the amount in its low byte |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | Lets the computed carry reach `carry_out` |
| operand_out | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Next carry value |

## Verification
The bench sweeps every register amount from 0 to 255 for all four shift kinds. This exposes a design that saturates the amount at 31 or that treats 32 like 33, since such a design returns the wrong carry at the boundary. Directed vectors cover the zero-field encodings. A design that missed them would return the input unshifted for logical or arithmetic right, or would rotate by zero instead of through carry. Further vectors check that upper count bits are ignored and that an immediate with zero rotation keeps the old carry. Random vectors in both forms, with set-flags toggled, catch a carry that leaks through while flag setting is off.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/sop_amount_sel.sv
module sop_amount_sel
  import sop_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic          amt_from_reg,
  input  logic [IW-1:0] amt_imm,
  input  logic [DW-1:0] cnt_reg,
  input  shift_kind_e   kind,
  output logic [CW-1:0] eff_cnt,
  output logic          rrx_sel
);
  always_comb begin
    rrx_sel = 1'b0;
    eff_cnt = CW'(amt_imm);
    if (amt_from_reg) begin
      eff_cnt = cnt_reg[CW-1:0];
    end else if (amt_imm == '0) begin
      unique case (kind)
        SH_LSL:  eff_cnt = '0;
        SH_LSR:  eff_cnt = CW'(DW);
        SH_ASR:  eff_cnt = CW'(DW);
        default: begin
          eff_cnt = '0;
          rrx_sel = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({amt_from_reg, amt_imm, kind})) begin
      // R8
      zero_field_chk: assert (amt_from_reg || amt_imm != '0 || kind == SH_ROR
                              || (eff_cnt == ((kind == SH_LSL) ? CW'(0) : CW'(DW))))
        else $error("zero field decode wrong");
    end
  end
endmodule

// File: rtl/sop_barrel.sv
module sop_barrel
  import sop_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8,
  localparam int RW = $clog2(DW)
) (
  input  logic [DW-1:0] src,
  input  shift_kind_e   kind,
  input  logic [CW-1:0] cnt,
  input  logic          rrx,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  logic [DW:0]          lsl_w;
  logic [DW:0]          lsr_w;
  logic signed [DW:0]   asr_w;
  logic [2*DW-1:0]      ror_w;
  logic [RW-1:0]        rot_amt;

  assign rot_amt = cnt[RW-1:0];
  assign lsl_w   = {1'b0, src} << cnt;
  assign lsr_w   = {src, 1'b0} >> cnt;
  assign asr_w   = $signed({src, 1'b0}) >>> cnt;
  assign ror_w   = {src, src} >> rot_amt;

  always_comb begin
    res  = src;
    cout = cin;
    if (rrx) begin
      res  = {cin, src[DW-1:1]};
      cout = src[0];
    end else if (cnt != '0) begin
      unique case (kind)
        SH_LSL: {cout, res} = lsl_w;
        SH_LSR: {res, cout} = lsr_w;
        SH_ASR: {res, cout} = asr_w;
        default: begin
          res  = ror_w[DW-1:0];
          cout = ror_w[DW-1];
        end
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({src, kind, cnt, rrx, cin})) begin
      // R3
      zero_pass_chk: assert (rrx || cnt != '0 || (res == src && cout == cin))
        else $error("zero amount altered data");
      // R4
      lsl_over_chk: assert (rrx || kind != SH_LSL || cnt <= CW'(DW) || (res == '0 && !cout))
        else $error("left shift past width not cleared");
      // R6
      asr_fill_chk: assert (rrx || kind != SH_ASR || cnt < CW'(DW)
                            || (res == {DW{src[DW-1]}} && cout == src[DW-1]))
        else $error("arithmetic fill wrong");
    end
  end
endmodule

// File: rtl/sop_imm_rot.sv
module sop_imm_rot #(
  parameter int DW  = 32,
  parameter int KW  = 8,
  parameter int RFW = 4,
  localparam int RW = $clog2(DW)
) (
  input  logic [KW-1:0]  imm,
  input  logic [RFW-1:0] rot_fld,
  input  logic           cin,
  output logic [DW-1:0]  res,
  output logic           cout
);
  logic [DW-1:0]   ext;
  logic [RW-1:0]   amt;
  logic [2*DW-1:0] dbl;

  assign ext  = DW'(imm);
  assign amt  = RW'({rot_fld, 1'b0});
  assign dbl  = {ext, ext} >> amt;
  assign res  = dbl[DW-1:0];
  assign cout = (amt != '0) ? res[DW-1] : cin;

  always_comb begin
    if (!$isunknown({imm, rot_fld, cin})) begin
      // R1
      imm_norot_chk: assert (rot_fld != '0 || (res == ext && cout == cin))
        else $error("unrotated constant altered");
      // R1
      imm_bits_chk: assert ($countones(res) == $countones(imm))
        else $error("rotation lost bits");
    end
  end
endmodule

// File: rtl/sop_shifter_unit.sv
module sop_shifter_unit
  import sop_pkg::*;
#(
  parameter int DW  = 32,
  parameter int KW  = 8,
  parameter int RFW = 4,
  parameter int CW  = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic          use_imm,
  input  logic [KW-1:0] imm_val,
  input  logic [RFW-1:0] imm_rot,
  input  logic [DW-1:0] src_val,
  input  logic [1:0]    sh_type,
  input  logic          amt_from_reg,
  input  logic [IW-1:0] amt_imm,
  input  logic [DW-1:0] cnt_reg,
  input  logic          carry_in,
  input  logic          set_flags,
  output logic [DW-1:0] operand_out,
  output logic          carry_out
);
  shift_kind_e   kind;
  logic [CW-1:0] eff_cnt;
  logic          rrx_sel;
  logic [DW-1:0] reg_res;
  logic          reg_c;
  logic [DW-1:0] imm_res;
  logic          imm_c;
  logic          sel_c;

  assign kind = shift_kind_e'(sh_type);

  sop_amount_sel #(.DW(DW), .CW(CW)) u_amt (
    .amt_from_reg (amt_from_reg),
    .amt_imm      (amt_imm),
    .cnt_reg      (cnt_reg),
    .kind         (kind),
    .eff_cnt      (eff_cnt),
    .rrx_sel      (rrx_sel)
  );

  sop_barrel #(.DW(DW), .CW(CW)) u_bar (
    .src  (src_val),
    .kind (kind),
    .cnt  (eff_cnt),
    .rrx  (rrx_sel),
    .cin  (carry_in),
    .res  (reg_res),
    .cout (reg_c)
  );

  sop_imm_rot #(.DW(DW), .KW(KW), .RFW(RFW)) u_imm (
    .imm     (imm_val),
    .rot_fld (imm_rot),
    .cin     (carry_in),
    .res     (imm_res),
    .cout    (imm_c)
  );

  always_comb begin
    if (use_imm) begin
      operand_out = imm_res;
      sel_c       = imm_c;
    end else begin
      operand_out = reg_res;
      sel_c       = reg_c;
    end
    carry_out = set_flags ? sel_c : carry_in;
  end

  always_comb begin
    if (!$isunknown({set_flags, carry_in, carry_out})) begin
      // R10
      flag_gate_chk: assert (set_flags || carry_out == carry_in)
        else $error("carry moved with flag setting off");
    end
  end
endmodule

// File: tb/sim_sop_shifter_unit.sv
module sim_sop_shifter_unit;
  logic        clk;
  logic        rst_n;
  logic        use_imm;
  logic [7:0]  imm_val;
  logic [3:0]  imm_rot;
  logic [31:0] src_val;
  logic [1:0]  sh_type;
  logic        amt_from_reg;
  logic [4:0]  amt_imm;
  logic [31:0] cnt_reg;
  logic        carry_in;
  logic        set_flags;
  logic [31:0] operand_out;
  logic        carry_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  sop_shifter_unit u0 (
    .use_imm(use_imm), .imm_val(imm_val), .imm_rot(imm_rot), .src_val(src_val),
    .sh_type(sh_type), .amt_from_reg(amt_from_reg), .amt_imm(amt_imm),
    .cnt_reg(cnt_reg), .carry_in(carry_in), .set_flags(set_flags),
    .operand_out(operand_out), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // bit-serial model: {carry, value}
  function automatic logic [32:0] model_shift(logic [31:0] v, logic [1:0] t, int n, logic c);
    logic [31:0] x = v;
    logic        k = c;
    for (int i = 0; i < n; i++) begin
      case (t)
        2'd0: begin k = x[31]; x = {x[30:0], 1'b0}; end
        2'd1: begin k = x[0];  x = {1'b0, x[31:1]}; end
        2'd2: begin k = x[0];  x = {x[31], x[31:1]}; end
        default: begin x = {x[0], x[31:1]}; k = x[31]; end
      endcase
    end
    return {k, x};
  endfunction

  function automatic logic [32:0] model(logic ui, logic [7:0] iv, logic [3:0] ir,
                                        logic [31:0] s, logic [1:0] t, logic fr,
                                        logic [4:0] ai, logic [31:0] cr, logic c, logic sf);
    logic [32:0] r;
    int n;
    if (ui) begin
      r = model_shift({24'd0, iv}, 2'd3, 2 * int'(ir), c);
    end else if (fr) begin
      r = model_shift(s, t, int'(cr[7:0]), c);
    end else if (ai == 0) begin
      if (t == 2'd0) r = {c, s};
      else if (t == 2'd3) r = {s[0], c, s[31:1]};
      else r = model_shift(s, t, 32, c);
    end else begin
      n = int'(ai);
      r = model_shift(s, t, n, c);
    end
    if (!sf) r[32] = c;
    return r;
  endfunction

  task automatic drive(logic ui, logic [7:0] iv, logic [3:0] ir, logic [31:0] s,
                       logic [1:0] t, logic fr, logic [4:0] ai, logic [31:0] cr,
                       logic c, logic sf);
    @(negedge clk);
    use_imm = ui; imm_val = iv; imm_rot = ir; src_val = s; sh_type = t;
    amt_from_reg = fr; amt_imm = ai; cnt_reg = cr; carry_in = c; set_flags = sf;
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] er, logic ec);
    total++;
    if (operand_out !== er || carry_out !== ec) begin
      bad++;
      $display("FAIL %s: got res=%08h c=%0b, want res=%08h c=%0b", tag, operand_out,
               carry_out, er, ec);
    end
  endtask

  task automatic run(string tag, logic ui, logic [7:0] iv, logic [3:0] ir, logic [31:0] s,
                     logic [1:0] t, logic fr, logic [4:0] ai, logic [31:0] cr,
                     logic c, logic sf);
    logic [32:0] e;
    e = model(ui, iv, ir, s, t, fr, ai, cr, c, sf);
    drive(ui, iv, ir, s, t, fr, ai, cr, c, sf);
    check(tag, e[31:0], e[32]);
  endtask

  function automatic string type_tag(logic [1:0] t);
    case (t)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    logic [31:0] pats [4];
    int unused_seed;
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // reset state: all-zero inputs give zero operand, zero carry
    check("R3", 32'd0, 1'b0);

    // R1 immediate rotations, including zero rotation keeping carry
    for (int r = 0; r < 16; r++) begin
      run("R1", 1, 8'hC3, 4'(r), 32'h0, 0, 0, 0, 0, 1'b1, 1);
      run("R1", 1, 8'h81, 4'(r), 32'h0, 0, 0, 0, 0, 1'b0, 1);
    end
    run("R1", 1, 8'h02, 4'd1, 32'h0, 0, 0, 0, 0, 1'b0, 1);  // 0x80000000, c=1
    check("R1", 32'h8000_0000, 1'b1);

    // full register-amount sweep for every kind
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hA5C3_0F96; pats[3] = 32'h1234_5678;
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 4; t++)
        for (int n = 0; n < 256; n++)
          run(n == 0 ? "R3" : type_tag(2'(t)), 0, 0, 0, pats[p], 2'(t), 1, 0,
              32'(n), 1'(p), 1);

    // explicit boundaries
    run("R4", 0, 0, 0, 32'h0000_0001, 2'd0, 1, 0, 32'd32, 0, 1); check("R4", 0, 1'b1);
    run("R4", 0, 0, 0, 32'hFFFF_FFFF, 2'd0, 1, 0, 32'd33, 1, 1); check("R4", 0, 1'b0);
    run("R5", 0, 0, 0, 32'h8000_0000, 2'd1, 1, 0, 32'd32, 0, 1); check("R5", 0, 1'b1);
    run("R5", 0, 0, 0, 32'hFFFF_FFFF, 2'd1, 1, 0, 32'd40, 1, 1); check("R5", 0, 1'b0);
    run("R6", 0, 0, 0, 32'h8000_0000, 2'd2, 1, 0, 32'd200, 0, 1); check("R6", 32'hFFFF_FFFF, 1'b1);
    run("R7", 0, 0, 0, 32'h0000_0001, 2'd3, 1, 0, 32'd33, 0, 1); check("R7", 32'h8000_0000, 1'b1);
    run("R7", 0, 0, 0, 32'h8000_0000, 2'd3, 1, 0, 32'd64, 0, 1); check("R7", 32'h8000_0000, 1'b1);

    // R2 upper count bits ignored
    run("R2", 0, 0, 0, 32'hF0F0_1234, 2'd1, 1, 0, 32'hFFFF_FF04, 0, 1);
    check("R2", 32'h0F0F_0123, 1'b0);
    run("R2", 0, 0, 0, 32'hF0F0_1234, 2'd0, 1, 0, 32'h1234_5600, 1, 1);
    check("R2", 32'hF0F0_1234, 1'b1);

    // R8 / R9 zero-field encodings
    run("R8", 0, 0, 0, 32'h8000_0001, 2'd0, 0, 5'd0, 0, 1, 1); check("R8", 32'h8000_0001, 1'b1);
    run("R8", 0, 0, 0, 32'h8000_0001, 2'd1, 0, 5'd0, 0, 0, 1); check("R8", 32'h0, 1'b1);
    run("R8", 0, 0, 0, 32'h8000_0001, 2'd2, 0, 5'd0, 0, 0, 1); check("R8", 32'hFFFF_FFFF, 1'b1);
    run("R9", 0, 0, 0, 32'h0000_0003, 2'd3, 0, 5'd0, 0, 1, 1); check("R9", 32'h8000_0001, 1'b1);
    run("R9", 0, 0, 0, 32'h8000_0002, 2'd3, 0, 5'd0, 0, 0, 1); check("R9", 32'h4000_0001, 1'b0);
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 32; a++)
        run(a == 0 ? (t == 3 ? "R9" : "R8") : type_tag(2'(t)), 0, 0, 0, 32'hC001_D00D,
            2'(t), 0, 5'(a), 32'hFFFF_FFFF, 1'(a), 1);

    // R10 carry held with flag setting off
    run("R10", 0, 0, 0, 32'h0000_0001, 2'd1, 1, 0, 32'd1, 0, 0); check("R10", 32'h0, 1'b0);
    run("R10", 1, 8'h80, 4'd4, 0, 0, 0, 0, 0, 0, 0); check("R10", 32'h8000_0000, 1'b0);

    // R11 register fields ignored in immediate form
    run("R11", 1, 8'h3C, 4'd2, 32'hFFFF_FFFF, 2'd2, 1, 5'd7, 32'd5, 1, 1);
    check("R11", 32'hC000_0003, 1'b1);
    run("R11", 1, 8'h3C, 4'd2, 32'h0, 2'd3, 0, 5'd0, 32'd0, 1, 1);
    check("R11", 32'hC000_0003, 1'b1);

    // constrained random mix
    unused_seed = $urandom(32'd4242);
    for (int i = 0; i < 3000; i++) begin
      logic ui, fr;
      logic [1:0] t;
      ui = ($urandom % 4) == 0;
      fr = $urandom % 2;
      t  = 2'($urandom);
      s  = $urandom;
      run(ui ? "R1" : (($urandom % 2) ? type_tag(t) : "R10"), ui, 8'($urandom),
          4'($urandom), s, t, fr, 5'($urandom), $urandom, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule